// File: doc/BRIEF.md
# Timed Serial Host with Selectable Target

The block is a register-mapped host for a serial peripheral bus inside an I/O subsystem. Software sees two registers. The control register holds the enable, a two-bit rate field, a two-bit target field, a select-hold bit and an interrupt-enable bit. The data register holds the byte to send. A write to the data register while the host is enabled starts a timed exchange. The host raises busy, counts down a transfer time of 2^(rate + CYC_SHIFT) system clocks, and hands its data byte to the chosen target. It then loads the target's reply into the data register, drops busy and, if allowed, pulses an interrupt.

Targets are outside the block. Each one sees a shared exchange strobe, the outgoing byte and a one-hot select line. It returns its reply byte in the same cycle. The power-manager slot is not wired to any reply input and always reads zero. A command-reset strobe tells every target to drop its partly received command. This strobe fires when the control register is written while select-hold was off. A target can therefore keep its command state across several bytes only while hold stays set.

Top module: `spi_rate_host`

## Requirements
- R1: A data-register write while enable (control bit 6) is 0 is ignored: busy stays 0, the data register keeps its value and no exchange strobe occurs.
- R2: An accepted data write sets busy (control read bit 7) from the next cycle. Busy stays set for exactly 2^(rate + CYC_SHIFT) cycles, where rate is control bits [1:0].
- R3: An accepted data write while busy restarts the countdown from full length with the new byte. Busy then lasts the cycles already elapsed plus a full length, and only one exchange and one completion follow.
- R4: The exchange strobe is high for one cycle, in the last cycle of busy. In that cycle the outgoing byte equals the data register, and the select is one-hot from target field bits [3:2]: code 0 touch drives select bit 0, code 1 flash drives bit 1, code 2 power drives bit 2, and code 3 drives no bit.
- R5: In the first cycle after busy, the data register holds the reply of the selected target: the touch input for code 0, the flash input for code 1, and 0x00 for codes 2 and 3.
- R6: The interrupt is a single-cycle pulse, present exactly in the first cycle busy reads 0 after a completion, and only if interrupt-enable (bit 5) is 1. It never pulses at any other time.
- R7: A control write made while the stored hold bit (bit 4) is 0 gives a one-cycle command-reset pulse in the next cycle. A control write made while hold is 1 gives none. The written hold value is stored either way.
- R8: After reset, both registers read 0 and all strobes are low. Control bits [6:0] read back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 7 | Control write value (enable, irq enable, hold, target, rate) |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | DATA_W | Byte to send |
| ctl_rdata | output | 8 | Control read value, bit 7 is busy |
| dat_rdata | output | DATA_W | Data register (reply after completion) |
| irq | output | 1 | One-cycle completion interrupt |
| xfer_strobe | output | 1 | Exchange strobe toward the targets |
| xfer_sel | output | 3 | One-hot target select |
| xfer_tx | output | DATA_W | Outgoing byte |
| xfer_rx_touch | input | DATA_W | Reply from touch/ADC target |
| xfer_rx_flash | input | DATA_W | Reply from flash target |
| cmd_rst | output | 1 | Command-state reset pulse to targets |

## Verification
The hardest case to reach is a restart. The second data write has to land while the first countdown is still running, so only one exchange and one interrupt may come out. The bench sets the slowest rate, which gives 32 cycles. It writes the second byte a fixed few cycles after the first. It then expects a single completion whose busy time is the gap plus a full length, carrying the reply to the second byte. The hold-gated command reset also depends on history. It is reached by alternating control writes with hold cleared and hold set, and by checking the strobe in the cycle after each write.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  localparam int CTL_W  = 7;
  localparam int RATE_W = 2;
  localparam int N_SEL  = 3;

  typedef enum logic [1:0] {
    TGT_TOUCH = 2'd0,
    TGT_FLASH = 2'd1,
    TGT_POWER = 2'd2,
    TGT_NONE  = 2'd3
  } tgt_e;

  typedef struct packed {
    logic              enable;
    logic              irq_en;
    logic              hold;
    tgt_e              tgt;
    logic [RATE_W-1:0] rate;
  } ctl_t;

endpackage

// File: rtl/spi_ctl_reg.sv
module spi_ctl_reg
  import spi_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output ctl_t             ctl_q,
  output logic [N_SEL-1:0] sel_q,
  output logic             cmd_rst_q
);

  ctl_t wr;
  assign wr = ctl_t'(wdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      cmd_rst_q <= 1'b0;
    end else begin
      cmd_rst_q <= we && !ctl_q.hold;
      if (we) ctl_q <= wr;
    end
  end

  for (genvar i = 0; i < N_SEL; i++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst)     sel_q[i] <= 1'b0;
      else if (we) sel_q[i] <= (wr.tgt == tgt_e'(i));
    end
  end

endmodule

// File: rtl/spi_rate_timer.sv
module spi_rate_timer
  import spi_host_pkg::*;
#(
  parameter int CYC_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [RATE_W-1:0] rate,
  output logic              busy_q,
  output logic              strobe_q
);

  localparam int MAX_EXP = (1 << RATE_W) - 1 + CYC_SHIFT;
  localparam int CNT_W   = (MAX_EXP < 1) ? 1 : MAX_EXP;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ones;
  logic [CNT_W-1:0] full_m1;
  logic [RATE_W-1:0] drop;

  assign ones    = '1;
  assign drop    = RATE_W'((1 << RATE_W) - 1) - rate;
  assign full_m1 = (MAX_EXP < 1) ? '0 : (ones >> drop);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else if (start) begin
      cnt_q    <= full_m1;
      busy_q   <= 1'b1;
      strobe_q <= (full_m1 == '0);
    end else if (strobe_q) begin
      busy_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q    <= cnt_q - 1'b1;
      strobe_q <= (cnt_q == CNT_W'(1));
    end
  end

endmodule

// File: rtl/spi_data_reg.sv
module spi_data_reg
  import spi_host_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done,
  input  tgt_e              tgt,
  input  logic              irq_en,
  input  logic [DATA_W-1:0] rx_touch,
  input  logic [DATA_W-1:0] rx_flash,
  output logic [DATA_W-1:0] data_q,
  output logic              irq_q
);

  logic [DATA_W-1:0] reply;

  always_comb begin
    unique case (tgt)
      TGT_TOUCH: reply = rx_touch;
      TGT_FLASH: reply = rx_flash;
      default:   reply = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= done && !start && irq_en;
      if (start)     data_q <= wdata;
      else if (done) data_q <= reply;
    end
  end

endmodule

// File: rtl/spi_rate_host.sv
module spi_rate_host
  import spi_host_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CYC_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [6:0]        ctl_wdata,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] dat_wdata,
  output logic [7:0]        ctl_rdata,
  output logic [DATA_W-1:0] dat_rdata,
  output logic              irq,
  output logic              xfer_strobe,
  output logic [2:0]        xfer_sel,
  output logic [DATA_W-1:0] xfer_tx,
  input  logic [DATA_W-1:0] xfer_rx_touch,
  input  logic [DATA_W-1:0] xfer_rx_flash,
  output logic              cmd_rst
);

  ctl_t ctl_q;
  logic busy;
  logic start;

  assign start = dat_we && ctl_q.enable;

  spi_ctl_reg u_ctl (
    .clk       (clk),
    .rst       (rst),
    .we        (ctl_we),
    .wdata     (ctl_wdata),
    .ctl_q     (ctl_q),
    .sel_q     (xfer_sel),
    .cmd_rst_q (cmd_rst)
  );

  spi_rate_timer #(.CYC_SHIFT(CYC_SHIFT)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rate     (ctl_q.rate),
    .busy_q   (busy),
    .strobe_q (xfer_strobe)
  );

  spi_data_reg #(.DATA_W(DATA_W)) u_dat (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .wdata    (dat_wdata),
    .done     (xfer_strobe),
    .tgt      (ctl_q.tgt),
    .irq_en   (ctl_q.irq_en),
    .rx_touch (xfer_rx_touch),
    .rx_flash (xfer_rx_flash),
    .data_q   (dat_rdata),
    .irq_q    (irq)
  );

  assign ctl_rdata = {busy, ctl_q};
  assign xfer_tx   = dat_rdata;

endmodule

// File: rtl/spi_rate_host_chk.sv
module spi_rate_host_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_we,
  input logic [6:0]        ctl_wdata,
  input logic              dat_we,
  input logic [DATA_W-1:0] dat_wdata,
  input logic [7:0]        ctl_rdata,
  input logic [DATA_W-1:0] dat_rdata,
  input logic              irq,
  input logic              xfer_strobe,
  input logic [2:0]        xfer_sel,
  input logic [DATA_W-1:0] xfer_tx,
  input logic [DATA_W-1:0] xfer_rx_touch,
  input logic [DATA_W-1:0] xfer_rx_flash,
  input logic              cmd_rst
);

  logic acc;
  assign acc = dat_we && ctl_rdata[6];

  AST_OFF_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    dat_we && !ctl_rdata[6] && !ctl_rdata[7] |=> !ctl_rdata[7]); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    acc |=> ctl_rdata[7] && xfer_tx == $past(dat_wdata)); // R2
  AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    xfer_strobe |-> ctl_rdata[7] && $onehot0(xfer_sel)); // R4
  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (rst)
    xfer_strobe && !acc |=> !xfer_strobe && !ctl_rdata[7]); // R4
  AST_TOUCH_REPLY: assert property (@(posedge clk) disable iff (rst)
    xfer_strobe && !acc && xfer_sel[0] |=> dat_rdata == $past(xfer_rx_touch)); // R5
  AST_FLASH_REPLY: assert property (@(posedge clk) disable iff (rst)
    xfer_strobe && !acc && xfer_sel[1] |=> dat_rdata == $past(xfer_rx_flash)); // R5
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R6
  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
    irq |-> $fell(ctl_rdata[7])); // R6
  AST_CMD_RST_OPEN: assert property (@(posedge clk) disable iff (rst)
    ctl_we && !ctl_rdata[4] |=> cmd_rst); // R7
  AST_CMD_RST_HELD: assert property (@(posedge clk) disable iff (rst)
    ctl_we && ctl_rdata[4] |=> !cmd_rst); // R7
  AST_CTL_READBACK: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> ctl_rdata[6:0] == $past(ctl_wdata)); // R8

endmodule

bind spi_rate_host spi_rate_host_chk #(.DATA_W(DATA_W)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .ctl_we        (ctl_we),
  .ctl_wdata     (ctl_wdata),
  .dat_we        (dat_we),
  .dat_wdata     (dat_wdata),
  .ctl_rdata     (ctl_rdata),
  .dat_rdata     (dat_rdata),
  .irq           (irq),
  .xfer_strobe   (xfer_strobe),
  .xfer_sel      (xfer_sel),
  .xfer_tx       (xfer_tx),
  .xfer_rx_touch (xfer_rx_touch),
  .xfer_rx_flash (xfer_rx_flash),
  .cmd_rst       (cmd_rst)
);

// File: tb/test_spi_rate_host.sv
module test_spi_rate_host;

  localparam int K = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_we = 1'b0;
  logic [6:0] ctl_wdata = '0;
  logic       dat_we = 1'b0;
  logic [7:0] dat_wdata = '0;
  logic [7:0] ctl_rdata, dat_rdata, xfer_tx, rx_touch, rx_flash;
  logic       irq, xfer_strobe, cmd_rst;
  logic [2:0] xfer_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign rx_touch = xfer_tx ^ 8'h5A;
  assign rx_flash = xfer_tx + 8'h11;

  spi_rate_host #(.DATA_W(8), .CYC_SHIFT(K)) i_spi_rate_host (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .ctl_rdata(ctl_rdata),
    .dat_rdata(dat_rdata), .irq(irq), .xfer_strobe(xfer_strobe),
    .xfer_sel(xfer_sel), .xfer_tx(xfer_tx), .xfer_rx_touch(rx_touch),
    .xfer_rx_flash(rx_flash), .cmd_rst(cmd_rst)
  );

  typedef struct {
    logic [7:0] data;
    logic       irq;
    int         len;
    logic [7:0] tx;
    logic [2:0] sel;
  } exp_t;

  exp_t exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] mk(input bit en, input bit ie, input bit hold,
                                    input logic [1:0] tgt, input logic [1:0] rate);
    return {en, ie, hold, tgt, rate};
  endfunction

  function automatic logic [7:0] reply_of(input logic [1:0] tgt, input logic [7:0] tx);
    case (tgt)
      2'd0:    return tx ^ 8'h5A;
      2'd1:    return tx + 8'h11;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [2:0] sel_of(input logic [1:0] tgt);
    return (tgt == 2'd3) ? 3'b000 : 3'(1 << tgt);
  endfunction

  task automatic wr_ctl(input logic [6:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); dat_we = 1'b1; dat_wdata = v;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic push(input logic [6:0] c, input logic [7:0] tx, input int len);
    exp_t e;
    e.data = reply_of(c[3:2], tx);
    e.irq  = c[5];
    e.len  = len;
    e.tx   = tx;
    e.sel  = sel_of(c[3:2]);
    exp_q.push_back(e);
  endtask

  // driver: one plain transfer (R2, R4, R5, R6)
  task automatic xfer(input logic [6:0] c, input logic [7:0] tx);
    wr_ctl(c);
    push(c, tx, 1 << (int'(c[1:0]) + K));
    wr_dat(tx);
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  // monitor
  int run = 0, nstb = 0;
  logic [7:0] stb_tx;
  logic [2:0] stb_sel;
  bit last_stb = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      run = 0; nstb = 0;
    end else begin
      if (!ctl_rdata[7] && xfer_strobe) check(1'b0, "R4 strobe outside busy", 1, 0);
      if (ctl_rdata[7]) begin
        run++;
        last_stb = xfer_strobe;
        if (xfer_strobe) begin nstb++; stb_tx = xfer_tx; stb_sel = xfer_sel; end
      end else if (run > 0) begin
        if (exp_q.size() == 0) check(1'b0, "R3 unexpected completion", run, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(run == e.len, "R2 busy length", run, e.len);
          check(nstb == 1 && last_stb, "R4 single strobe at end", nstb, 1);
          check(stb_tx == e.tx, "R4 outgoing byte", stb_tx, e.tx);
          check(stb_sel == e.sel, "R4 select", stb_sel, e.sel);
          check(dat_rdata == e.data, "R5 reply loaded", dat_rdata, e.data);
          check(irq == e.irq, "R6 irq at completion", irq, e.irq);
        end
        run = 0; nstb = 0;
      end else if (irq) check(1'b0, "R6 stray irq", 1, 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check(ctl_rdata == 8'h00, "R8 ctl reset", ctl_rdata, 0);
    check(dat_rdata == 8'h00, "R8 data reset", dat_rdata, 0);
    check(!irq && !xfer_strobe && !cmd_rst, "R8 strobes low", {irq, xfer_strobe, cmd_rst}, 0);

    // R1: disabled write ignored
    wr_ctl(mk(0, 1, 0, 2'd0, 2'd0));
    wr_dat(8'h3C);
    check(ctl_rdata[7] == 1'b0, "R1 busy stays low", ctl_rdata[7], 0);
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (xfer_strobe || ctl_rdata[7]) seen = 1'b1;
      end
      check(!seen, "R1 no exchange", seen, 0);
    end
    check(dat_rdata == 8'h00, "R1 data kept", dat_rdata, 0);

    // R2/R4/R5/R6 across targets and rates
    xfer(mk(1, 1, 0, 2'd0, 2'd0), 8'hC3);
    xfer(mk(1, 0, 0, 2'd1, 2'd2), 8'h7E);
    xfer(mk(1, 1, 0, 2'd2, 2'd1), 8'h99);
    xfer(mk(1, 1, 0, 2'd3, 2'd0), 8'h42);
    xfer(mk(1, 1, 0, 2'd1, 2'd3), 8'hF0);

    // R3: restart while busy at slowest rate
    wr_ctl(mk(1, 1, 0, 2'd0, 2'd3));
    push(mk(1, 1, 0, 2'd0, 2'd3), 8'h5B, 2 + 2 + (1 << (3 + K)));
    wr_dat(8'h11);
    repeat (2) @(negedge clk);
    wr_dat(8'h5B);
    wait (exp_q.size() == 0);
    @(negedge clk);
    check(exp_q.size() == 0 && run == 0, "R3 single completion", run, 0);

    // R7 hold gating of command reset
    wr_ctl(mk(1, 0, 1, 2'd1, 2'd0));
    check(cmd_rst == 1'b1, "R7 reset when hold was off", cmd_rst, 1);
    @(negedge clk);
    check(cmd_rst == 1'b0, "R7 reset is one cycle", cmd_rst, 0);
    wr_ctl(mk(1, 0, 0, 2'd1, 2'd0));
    check(cmd_rst == 1'b0, "R7 no reset while hold on", cmd_rst, 0);
    wr_ctl(mk(1, 0, 0, 2'd1, 2'd0));
    check(cmd_rst == 1'b1, "R7 reset after hold cleared", cmd_rst, 1);

    // R8 readback
    wr_ctl(7'h55);
    check(ctl_rdata == 8'h55, "R8 readback", ctl_rdata, 8'h55);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule